// File: doc/BRIEF.md
# Quad-Pumped Data Receiver with Inversion

This block is the receive side of a 64-bit source-synchronous data bus that moves four beats in every common clock period. The bus is cut into four 16-bit lanes. Each lane brings its own pair of interleaved strobes and its own polarity flag. The falling edges of the two strobes capture the beats into a small per-lane buffer that runs in the strobe domain. The polarity is restored per lane and per beat at capture.

In the common clock domain, a data-ready qualifier from the driving agent marks the clock period in which a transfer took place. One clock later the block reads the four lanes out of their buffers, aligns them and presents a 256-bit line with a one-cycle valid pulse. A busy tracker reports whether the data bus is still in use. That is the case while the driving agent holds its busy pin, and also while a qualified transfer has not yet been delivered.

Top module: `qpump_rx`

## Requirements
- R1: The output line holds lane g of beat b at bits [b*64 + g*16 +: 16]: lane 0 is pins 15:0 up to lane 3 on pins 63:48, and beat 0 sits in the least significant 64 bits.
- R2: For every lane, the first and second falling edges of its P strobe in a transfer capture beats 0 and 2, and the first and second falling edges of its N strobe capture beats 1 and 3.
- R3: Data, strobe, polarity, ready and busy pins are active low. With a lane's polarity pin high, a captured bit is the complement of the sampled pin level.
- R4: With a lane's polarity pin low on the capturing strobe edge, that lane's bits for that beat are taken as the sampled pin level. The flag is evaluated independently per lane and per beat.
- R5: When the clock edge E1 samples the ready pin low, the line and a high valid appear after edge E2, and valid falls again after E3 unless another transfer was qualified at E2.
- R6: Valid is never raised unless the ready pin was sampled low two clock edges earlier.
- R7: Transfers in consecutive clock periods, with ready held low, are delivered in order on consecutive cycles, each with its own valid.
- R8: Bus busy goes high after the first clock edge that samples the busy pin low. It stays high until an edge samples the pin high again.
- R9: Bus busy is also high in the cycle between the edge that qualifies a transfer and the edge that delivers it.
- R10: During and after reset, the line is zero and valid and bus busy are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Common clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dq_n | input | 64 | Quad-pumped data pins, active low |
| stb_p_n | input | 4 | P strobe per lane; falling edge captures beats 0 and 2 |
| stb_n_n | input | 4 | N strobe per lane; falling edge captures beats 1 and 3 |
| inv_n | input | 4 | Polarity flag per lane, low means the lane is sent inverted |
| rdy_n | input | 1 | Data-ready qualifier, low for the period of a transfer |
| busy_n | input | 1 | Data-bus-busy pin of the driving agent, active low |
| line_data | output | 256 | Received line, beat 0 in bits 63:0 |
| line_vld | output | 1 | One-cycle pulse per delivered line |
| bus_busy | output | 1 | Data bus is in use |

## Verification
A transfer's strobes fall inside one clock period. The edge that ends that period samples ready, and the line and valid are due after the next edge, so the bench reads them half a period after that second edge. It then confirms one edge later that valid has dropped. Bus busy is due one edge after the busy pin or the ready pin changes. The bench checks it first in the half period before that edge, where the old value must still show, and again after the edge. All checks sample at the falling clock edge, and all pins change 1 ns after a rising edge, so no check races a register.

// File: rtl/qpump_pkg.sv
`timescale 1ns/1ps
package qpump_pkg;
   localparam int unsigned DEF_GROUPS = 4;
   localparam int unsigned DEF_GW     = 16;
   localparam int unsigned DEF_PUMP   = 4;
   localparam int unsigned DEF_SLOTS  = 2;

   function automatic bit is_pow2(input int unsigned v);
      return (v != 0) && ((v & (v - 1)) == 0);
   endfunction
endpackage

// File: rtl/qpump_grp_cap.sv
`timescale 1ns/1ps
module qpump_grp_cap #(
   parameter int unsigned GW    = 16,
   parameter int unsigned PUMP  = 4,
   parameter int unsigned SLOTS = 2
) (
   input  logic                      rst_n,
   input  logic                      stbp_n,
   input  logic                      stbn_n,
   input  logic [GW-1:0]             pin_n,
   input  logic                      inv_n,
   input  logic [$clog2(SLOTS)-1:0]  rd_slot,
   output logic [PUMP*GW-1:0]        beats
);
   localparam int unsigned HALF = PUMP / 2;
   localparam int unsigned HW   = $clog2(HALF);
   localparam int unsigned SW   = $clog2(SLOTS);
   localparam int unsigned PW   = HW + SW;

   logic [PW-1:0] p_ptr, n_ptr;
   logic [GW-1:0] p_mem [SLOTS][HALF];
   logic [GW-1:0] n_mem [SLOTS][HALF];
   logic [GW-1:0] true_bits;

   // Pins are active low; an asserted polarity flag cancels that conversion.
   assign true_bits = inv_n ? ~pin_n : pin_n;

   always_ff @(negedge stbp_n or negedge rst_n) begin
      if (!rst_n) p_ptr <= '0;
      else        p_ptr <= p_ptr + 1'b1;
   end

   always_ff @(negedge stbn_n or negedge rst_n) begin
      if (!rst_n) n_ptr <= '0;
      else        n_ptr <= n_ptr + 1'b1;
   end

   always_ff @(negedge stbp_n) begin
      p_mem[p_ptr[PW-1:HW]][p_ptr[HW-1:0]] <= true_bits;
   end

   always_ff @(negedge stbn_n) begin
      n_mem[n_ptr[PW-1:HW]][n_ptr[HW-1:0]] <= true_bits;
   end

   // P edges hold even beats, N edges hold odd beats.
   for (genvar h = 0; h < HALF; h++) begin : g_rd
      assign beats[(2*h)*GW   +: GW] = p_mem[rd_slot][h];
      assign beats[(2*h+1)*GW +: GW] = n_mem[rd_slot][h];
   end
endmodule

// File: rtl/qpump_line_join.sv
`timescale 1ns/1ps
module qpump_line_join #(
   parameter int unsigned GROUPS = 4,
   parameter int unsigned GW     = 16,
   parameter int unsigned PUMP   = 4,
   parameter int unsigned SLOTS  = 2
) (
   input  logic                            clk,
   input  logic                            rst_n,
   input  logic                            rdy_n,
   input  logic [GROUPS*PUMP*GW-1:0]       grp_beats,
   output logic [$clog2(SLOTS)-1:0]        rd_slot,
   output logic [GROUPS*PUMP*GW-1:0]       line_data,
   output logic                            line_vld,
   output logic                            pending
);
   localparam int unsigned LW = GROUPS * PUMP * GW;

   logic          rdy_q;
   logic [LW-1:0] aligned;
   logic [1:0]    age;

   // Reorder lane-major storage into beat-major output.
   for (genvar g = 0; g < GROUPS; g++) begin : g_lane
      for (genvar b = 0; b < PUMP; b++) begin : g_beat
         assign aligned[(b*GROUPS + g)*GW +: GW] = grp_beats[(g*PUMP + b)*GW +: GW];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rdy_q     <= 1'b0;
         rd_slot   <= '0;
         line_data <= '0;
         line_vld  <= 1'b0;
      end else begin
         rdy_q    <= ~rdy_n;
         line_vld <= rdy_q;
         if (rdy_q) begin
            line_data <= aligned;
            rd_slot   <= rd_slot + 1'b1;
         end
      end
   end

   assign pending = rdy_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         age <= 2'd0;
      else if (age != 2'd3) age <= age + 2'd1;
   end

   assert_vld_latency_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (age == 2'd3 && $past(!rdy_n, 2)) |-> line_vld);

   assert_no_stray_vld_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (age == 2'd3 && !$past(!rdy_n, 2)) |-> !line_vld);

   assert_slot_advance_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (age != 2'd0 && line_vld) |-> (rd_slot != $past(rd_slot)));
endmodule

// File: rtl/qpump_busy.sv
`timescale 1ns/1ps
module qpump_busy (
   input  logic clk,
   input  logic rst_n,
   input  logic busy_n,
   input  logic pending,
   output logic bus_busy
);
   logic pin_q;
   logic armed;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pin_q <= 1'b0;
         armed <= 1'b0;
      end else begin
         pin_q <= ~busy_n;
         armed <= 1'b1;
      end
   end

   assign bus_busy = pin_q | pending;

   assert_busy_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (armed && $past(!busy_n)) |-> bus_busy);

   assert_busy_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (armed && $past(busy_n) && !pending) |-> !bus_busy);
endmodule

// File: rtl/qpump_rx.sv
`timescale 1ns/1ps
module qpump_rx #(
   parameter int unsigned GROUPS = qpump_pkg::DEF_GROUPS,
   parameter int unsigned GW     = qpump_pkg::DEF_GW,
   parameter int unsigned PUMP   = qpump_pkg::DEF_PUMP,
   parameter int unsigned SLOTS  = qpump_pkg::DEF_SLOTS
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic [GROUPS*GW-1:0]       dq_n,
   input  logic [GROUPS-1:0]          stb_p_n,
   input  logic [GROUPS-1:0]          stb_n_n,
   input  logic [GROUPS-1:0]          inv_n,
   input  logic                       rdy_n,
   input  logic                       busy_n,
   output logic [GROUPS*PUMP*GW-1:0]  line_data,
   output logic                       line_vld,
   output logic                       bus_busy
);
   localparam int unsigned SW = $clog2(SLOTS);

   if (!qpump_pkg::is_pow2(PUMP) || PUMP < 4) begin : g_bad_pump
      $error("PUMP must be a power of two of at least 4");
   end
   if (!qpump_pkg::is_pow2(SLOTS) || SLOTS < 2) begin : g_bad_slots
      $error("SLOTS must be a power of two of at least 2");
   end
   if (GROUPS == 0 || GW == 0) begin : g_bad_width
      $error("GROUPS and GW must be non-zero");
   end

   logic [SW-1:0]                rd_slot;
   logic [GROUPS*PUMP*GW-1:0]    grp_beats;
   logic                         pending;

   for (genvar g = 0; g < GROUPS; g++) begin : g_cap
      qpump_grp_cap #(.GW(GW), .PUMP(PUMP), .SLOTS(SLOTS)) u_cap (
         .rst_n  (rst_n),
         .stbp_n (stb_p_n[g]),
         .stbn_n (stb_n_n[g]),
         .pin_n  (dq_n[g*GW +: GW]),
         .inv_n  (inv_n[g]),
         .rd_slot(rd_slot),
         .beats  (grp_beats[g*PUMP*GW +: PUMP*GW])
      );
   end

   qpump_line_join #(.GROUPS(GROUPS), .GW(GW), .PUMP(PUMP), .SLOTS(SLOTS)) u_join (
      .clk      (clk),
      .rst_n    (rst_n),
      .rdy_n    (rdy_n),
      .grp_beats(grp_beats),
      .rd_slot  (rd_slot),
      .line_data(line_data),
      .line_vld (line_vld),
      .pending  (pending)
   );

   qpump_busy u_busy (
      .clk     (clk),
      .rst_n   (rst_n),
      .busy_n  (busy_n),
      .pending (pending),
      .bus_busy(bus_busy)
   );

   logic armed;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) armed <= 1'b0;
      else        armed <= 1'b1;
   end

   assert_busy_pending_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (armed && $past(!rdy_n)) |-> bus_busy);

   assert_reset_quiet_R10: assert property (@(posedge clk)
      !rst_n |-> (!line_vld && line_data == '0));
endmodule

// File: tb/qpump_rx_tb.sv
`timescale 1ns/100ps
module qpump_rx_tb;
   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic [63:0]  dq_n = '1;
   logic [3:0]   stb_p_n = '1;
   logic [3:0]   stb_n_n = '1;
   logic [3:0]   inv_n = '1;
   logic         rdy_n = 1'b1;
   logic         busy_n = 1'b1;
   logic [255:0] line_data;
   logic         line_vld;
   logic         bus_busy;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   qpump_rx u_dut (
      .clk(clk), .rst_n(rst_n), .dq_n(dq_n), .stb_p_n(stb_p_n),
      .stb_n_n(stb_n_n), .inv_n(inv_n), .rdy_n(rdy_n), .busy_n(busy_n),
      .line_data(line_data), .line_vld(line_vld), .bus_busy(bus_busy)
   );

   // Stimulus table: seed for the line contents, polarity bit per beat*4+lane.
   localparam int NV = 6;
   localparam logic [31:0] V_SEED [NV] = '{32'h0000_0001, 32'h1234_5678, 32'hDEAD_BEEF,
                                            32'h0BAD_F00D, 32'h0000_0000, 32'hC001_D00D};
   localparam logic [15:0] V_INV  [NV] = '{16'h0000, 16'hFFFF, 16'h0F0F,
                                            16'h5A5A, 16'h8421, 16'h3C96};
   localparam string       V_REQ  [NV] = '{"R3", "R4", "R4", "R1", "R2", "R4"};

   function automatic logic [255:0] mk_line(input logic [31:0] seed);
      logic [255:0] l;
      for (int i = 0; i < 8; i++) begin
         l[i*32 +: 32] = (seed + 32'(i)) * 32'h9E37_79B1 ^ {24'h0, 8'(i * 17)};
      end
      return l;
   endfunction

   task automatic check(input string req, input logic [255:0] act, input logic [255:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // Drives one transfer starting 1 ns after a rising edge; ends before the next.
   task automatic xfer(input logic [255:0] l, input logic [15:0] inv);
      #1;
      rdy_n = 1'b0;
      for (int b = 0; b < 4; b++) begin
         for (int g = 0; g < 4; g++) begin
            dq_n[g*16 +: 16] = inv[b*4+g] ? l[b*64+g*16 +: 16] : ~l[b*64+g*16 +: 16];
            inv_n[g]         = ~inv[b*4+g];
         end
         #0.5;
         if (b % 2 == 0) stb_p_n = 4'h0; else stb_n_n = 4'h0;
         #0.5;
         stb_p_n = 4'hF;
         stb_n_n = 4'hF;
         #0.5;
      end
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [255:0] la, lb;
      repeat (4) @(posedge clk);
      #4;
      check("R10", {line_data, 254'(0)} >> 254, 256'(0));
      check("R10", line_data, 256'(0));
      check("R10", {254'(0), line_vld, bus_busy}, 256'(0));
      rst_n = 1'b1;

      for (int v = 0; v < NV; v++) begin
         la = mk_line(V_SEED[v]);
         if (v == 4) la = {64'h3333_3333_3333_3333, 64'h2222_2222_2222_2222,
                           64'h1111_1111_1111_1111, 64'h0000_0000_0000_0000};
         @(posedge clk);
         xfer(la, V_INV[v]);
         @(posedge clk);
         #1 rdy_n = 1'b1;
         #3;
         check("R9", 256'(bus_busy), 256'(1));
         check("R5", 256'(line_vld), 256'(0));
         @(posedge clk);
         #4;
         check("R5", 256'(line_vld), 256'(1));
         check(V_REQ[v], line_data, la);
         check("R9", 256'(bus_busy), 256'(0));
         @(posedge clk);
         #4;
         check("R5", 256'(line_vld), 256'(0));
      end

      // R7: back-to-back transfers
      la = mk_line(32'h7777_0001);
      lb = mk_line(32'h7777_0002);
      @(posedge clk);
      xfer(la, 16'h1248);
      @(posedge clk);
      xfer(lb, 16'hE0E0);
      @(posedge clk);
      #1 rdy_n = 1'b1;
      #3;
      check("R7", 256'(line_vld), 256'(1));
      check("R7", line_data, la);
      @(posedge clk);
      #4;
      check("R7", 256'(line_vld), 256'(1));
      check("R7", line_data, lb);
      @(posedge clk);
      #4;
      check("R7", 256'(line_vld), 256'(0));

      // R6: no ready, no valid
      begin
         int seen = 0;
         for (int c = 0; c < 10; c++) begin
            @(posedge clk);
            #4;
            if (line_vld) seen++;
         end
         check("R6", 256'(seen), 256'(0));
      end

      // R8: busy pin tracking
      @(posedge clk);
      #1 busy_n = 1'b0;
      #3 check("R8", 256'(bus_busy), 256'(0));
      @(posedge clk);
      #4 check("R8", 256'(bus_busy), 256'(1));
      repeat (3) @(posedge clk);
      #4 check("R8", 256'(bus_busy), 256'(1));
      @(posedge clk);
      #1 busy_n = 1'b1;
      #3 check("R8", 256'(bus_busy), 256'(1));
      @(posedge clk);
      #4 check("R8", 256'(bus_busy), 256'(0));

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule